// File: doc/BRIEF.md
# Row-Only Refresh Controller for Asynchronous DRAM

This block keeps an asynchronous DRAM alive when the DRAM has no refresh counter of its own. The block holds the row pointer itself and runs a free-running interval timer. When a refresh falls due, it takes the shared row-strobe, column-strobe and multiplexed address pins away from the access engine. It puts the current row on the address pins and pulls the row strobe low for a fixed number of clocks, while the column strobe stays inactive. It then lets the row strobe recover for a fixed precharge time and moves the pointer on to the next row.

The access engine reaches the pins through a request/grant handshake. It raises `acc_req` and waits for `acc_grant`. While the grant is high, its own strobe and address values pass straight through to the DRAM pins. It holds `acc_req` until its cycle is done, and dropping the request ends the access. A refresh that falls due during an access waits until that access ends. The refresh then goes ahead of any request that is already waiting. `ref_busy` marks the whole refresh cycle, from the start of the strobe pulse to the end of precharge.

Top module: `refctl_top`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, both strobes are high (inactive), `acc_grant` is 0 and `ref_busy` is 0, even if the access engine drives its strobes low.
- R2: Each refresh holds `dram_ras_n` low for exactly RAS_LOW consecutive clocks, and `dram_addr` stays constant for the whole pulse.
- R3: `dram_cas_n` stays high throughout every refresh cycle. When no grant is held, the access engine's strobe inputs have no effect on the DRAM pins.
- R4: Refreshes address rows 0, 1, 2 … ROWS-1 in order, zero-extended to the address width. After row ROWS-1 the next refresh addresses row 0, including when ROWS is not a power of two.
- R5: With the access port idle, consecutive refresh pulses begin exactly INTERVAL clocks apart.
- R6: After each refresh pulse, `dram_ras_n` stays high for at least RAS_PRE clocks before the next refresh pulse begins. `ref_busy` stays high for exactly RAS_PRE clocks after the pulse ends.
- R7: Once granted, `acc_grant` stays high for as long as `acc_req` is held. No refresh starts during that time, even if the access outlasts several intervals.
- R8: When a refresh is pending at the moment an access ends, that refresh starts before any grant is given to a request that is already waiting.
- R9: `ref_busy` is high during the strobe pulse and the precharge of a refresh. `ref_busy` and `acc_grant` are never high together.
- R10: With no refresh pending, a request made while the controller is idle is granted one clock later. While granted, `dram_addr`, `dram_ras_n` and `dram_cas_n` follow `acc_addr`, `acc_ras_n` and `acc_cas_n` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access engine requests the DRAM pins and holds the request for the length of its cycle |
| acc_addr | input | ADDR_W | Address from the access engine |
| acc_ras_n | input | 1 | Row strobe from the access engine |
| acc_cas_n | input | 1 | Column strobe from the access engine |
| acc_grant | output | 1 | The DRAM pins belong to the access engine |
| ref_busy | output | 1 | A refresh cycle (pulse or precharge) is in progress |
| dram_addr | output | ADDR_W | Multiplexed DRAM address pins |
| dram_ras_n | output | 1 | DRAM row strobe, active low |
| dram_cas_n | output | 1 | DRAM column strobe, active low |

## Verification
The bench builds the block with ROWS=6, ADDR_W=4, INTERVAL=40, RAS_LOW=3 and RAS_PRE=2. With six rows, a non-power-of-two wrap comes round every few hundred clocks, so more than three full passes over the rows are checked for order and pulse shape. A 40-clock interval lets a single 60-clock access span a timer expiry, which brings the deferred refresh and its priority over a waiting request within reach. The short pulse and precharge values leave room for a sweep of access lengths from one to twelve clocks.

// File: rtl/refctl_pkg.sv
package refctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_RAS_LO  = 2'd2,
    ST_RAS_PRE = 2'd3
  } refctl_state_e;

endpackage

// File: rtl/refctl_interval_timer.sv
module refctl_interval_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? RELOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  // R5: the counter never exceeds its reload value
  p_timer_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);

endmodule

// File: rtl/refctl_row_counter.sv
module refctl_row_counter #(
  parameter int ROWS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] row
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_d;
  logic          row_en;

  always_comb begin
    row_en = adv;
    row_d  = (row_q == LAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  assign row = row_q;

  p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adv) && $past(row_q) == LAST) |-> row_q == '0);

  p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adv) |-> $stable(row_q));

endmodule

// File: rtl/refctl_sequencer.sv
module refctl_sequencer
  import refctl_pkg::*;
#(
  parameter int RAS_LOW = 4,
  parameter int RAS_PRE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend,
  input  logic          acc_req,
  output refctl_state_e state,
  output logic          start,
  output logic          adv
);
  localparam int MAXT = (RAS_LOW > RAS_PRE) ? RAS_LOW : RAS_PRE;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] LO_LOAD  = TW'(RAS_LOW - 1);
  localparam logic [TW-1:0] PRE_LOAD = TW'(RAS_PRE - 1);

  refctl_state_e st_q, st_d;
  logic [TW-1:0] t_q, t_d;

  always_comb begin
    st_d  = st_q;
    t_d   = t_q;
    start = 1'b0;
    adv   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend) begin
          st_d  = ST_RAS_LO;
          t_d   = LO_LOAD;
          start = 1'b1;
        end else if (acc_req) begin
          st_d = ST_ACCESS;
        end
      end
      ST_ACCESS: begin
        if (!acc_req) st_d = ST_IDLE;
      end
      ST_RAS_LO: begin
        if (t_q == '0) begin
          st_d = ST_RAS_PRE;
          t_d  = PRE_LOAD;
          adv  = 1'b1;
        end else begin
          t_d = t_q - 1'b1;
        end
      end
      ST_RAS_PRE: begin
        if (t_q == '0) st_d = ST_IDLE;
        else           t_d  = t_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      t_q  <= '0;
    end else begin
      st_q <= st_d;
      t_q  <= t_d;
    end
  end

  assign state = st_q;

  p_pre_follows_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_RAS_LO && st_q != ST_RAS_LO) |-> st_q == ST_RAS_PRE);

  p_access_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACCESS && acc_req) |=> st_q == ST_ACCESS);

  p_low_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RAS_LO && $past(st_q) != ST_RAS_LO) |-> t_q == LO_LOAD);

endmodule

// File: rtl/refctl_top.sv
module refctl_top
  import refctl_pkg::*;
#(
  parameter int ROWS     = 512,
  parameter int ADDR_W   = 10,
  parameter int INTERVAL = 780,
  parameter int RAS_LOW  = 4,
  parameter int RAS_PRE  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_ras_n,
  input  logic              acc_cas_n,
  output logic              acc_grant,
  output logic              ref_busy,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rs_q[SYNC_STAGES-1];

  logic          tick, start, adv;
  logic          pend_q, pend_d, pend_en;
  logic [RW-1:0] row;
  refctl_state_e state;

  refctl_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_ns), .tick(tick));

  refctl_row_counter #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst_n(rst_ns), .adv(adv), .row(row));

  refctl_sequencer #(.RAS_LOW(RAS_LOW), .RAS_PRE(RAS_PRE)) u_seq (
    .clk(clk), .rst_n(rst_ns), .pend(pend_q), .acc_req(acc_req),
    .state(state), .start(start), .adv(adv));

  // pending flag: a new expiry wins over a same-cycle start
  always_comb begin
    pend_en = tick | start;
    pend_d  = tick | (pend_q & ~start);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  // row padded to the pin width
  logic [ADDR_W-1:0] row_pins;
  generate
    if (ADDR_W > RW) begin : g_pad
      assign row_pins = {{(ADDR_W-RW){1'b0}}, row};
    end else begin : g_trim
      assign row_pins = row[ADDR_W-1:0];
    end
  endgenerate

  // pin ownership
  always_comb begin
    acc_grant = (state == ST_ACCESS);
    ref_busy  = (state == ST_RAS_LO) || (state == ST_RAS_PRE);
    if (acc_grant) begin
      dram_addr  = acc_addr;
      dram_ras_n = acc_ras_n;
      dram_cas_n = acc_cas_n;
    end else begin
      dram_addr  = row_pins;
      dram_ras_n = (state != ST_RAS_LO);
      dram_cas_n = 1'b1;
    end
  end

  p_grant_busy_excl_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !(acc_grant && ref_busy));

  p_cas_quiet_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    ref_busy |-> dram_cas_n);

  p_pending_first_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (pend_q && !acc_grant && !ref_busy) |=> (ref_busy && !dram_ras_n));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    (ref_busy && !dram_ras_n && $past(ref_busy && !dram_ras_n)) |-> $stable(dram_addr));

endmodule

// File: tb/tb_refctl_top.sv
module tb_refctl_top;
  localparam int ROWS = 6, AW = 4, IVL = 40, RLO = 3, RPR = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, acc_req, acc_ras_n, acc_cas_n;
  logic [AW-1:0] acc_addr;
  logic          acc_grant, ref_busy, dram_ras_n, dram_cas_n;
  logic [AW-1:0] dram_addr;

  refctl_top #(.ROWS(ROWS), .ADDR_W(AW), .INTERVAL(IVL), .RAS_LOW(RLO), .RAS_PRE(RPR)) dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
    .acc_ras_n(acc_ras_n), .acc_cas_n(acc_cas_n), .acc_grant(acc_grant),
    .ref_busy(ref_busy), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n));

  int vec = 0, bad = 0, cyc = 0;
  bit done = 0, mon_en = 0, chk_int = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  // refresh monitor
  bit in_pulse = 0, after_ref = 0, have_start = 0, gnt_since = 0, cas_ok = 1;
  int plen = 0, paddr = 0, exp_row = 0, last_start = 0, hi_cnt = 0, pulses = 0;

  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (acc_grant) begin
        gnt_since = 1;
        after_ref = 0;
      end
      if (!dram_ras_n && !acc_grant) begin
        if (!in_pulse) begin
          if (after_ref) chk(hi_cnt >= RPR, "R6 precharge high time", hi_cnt, RPR);
          if (have_start && chk_int && !gnt_since)
            chk(cyc - last_start == IVL, "R5 refresh spacing", cyc - last_start, IVL);
          last_start = cyc; have_start = 1; gnt_since = 0;
          in_pulse = 1; plen = 0; paddr = int'(dram_addr); cas_ok = 1; after_ref = 0;
        end
        plen++;
        if (int'(dram_addr) != paddr) chk(0, "R2 address moved in pulse", int'(dram_addr), paddr);
        if (!dram_cas_n) cas_ok = 0;
        if (!ref_busy) chk(0, "R9 busy in pulse", 0, 1);
      end else if (in_pulse) begin
        in_pulse = 0; pulses++;
        chk(plen == RLO, "R2 pulse length", plen, RLO);
        chk(paddr == exp_row, "R4 row order", paddr, exp_row);
        chk(cas_ok, "R3 cas during refresh", 0, 1);
        exp_row = (exp_row + 1) % ROWS;
        after_ref = 1; hi_cnt = 1;
        chk(ref_busy == 1'b1, "R6 busy in precharge", ref_busy, 1);
        chk(dram_cas_n == 1'b1, "R3 cas in precharge", dram_cas_n, 1);
      end else begin
        if (after_ref) begin
          hi_cnt++;
          if (hi_cnt <= RPR + 1)
            chk(ref_busy == (hi_cnt <= RPR), "R6 busy length", ref_busy, hi_cnt <= RPR);
        end
        if (!acc_grant && !ref_busy)
          chk(dram_ras_n && dram_cas_n, "R3 pins ignore engine", {dram_ras_n, dram_cas_n}, 3);
      end
    end
  end

  task automatic do_access(input int len, input logic [AW-1:0] a,
                           output int waited, output bit ref_first);
    @(negedge clk);
    acc_req = 1; acc_addr = a; acc_ras_n = 1; acc_cas_n = 1;
    ref_first = 0; waited = 0;
    do begin
      @(negedge clk); #1;
      waited++;
      if (ref_busy) ref_first = 1;
    end while (!acc_grant && waited < 200);
    for (int i = 0; i < len; i++) begin
      acc_ras_n = i[0]; acc_cas_n = ~i[0]; acc_addr = a ^ AW'(i);
      #1;
      chk(acc_grant, "R7 grant held", acc_grant, 1);
      chk(!ref_busy, "R7 no refresh during access", ref_busy, 0);
      chk(dram_ras_n == acc_ras_n && dram_cas_n == acc_cas_n && dram_addr == acc_addr,
          "R10 passthrough", int'(dram_addr), int'(acc_addr));
      @(negedge clk);
    end
    acc_req = 0; acc_ras_n = 0; acc_cas_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    int w;
    bit rf;
    rst_n = 0; acc_req = 0; acc_addr = '0; acc_ras_n = 0; acc_cas_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(dram_ras_n && dram_cas_n, "R1 reset strobes", {dram_ras_n, dram_cas_n}, 3);
    chk(!acc_grant && !ref_busy, "R1 reset grant/busy", {acc_grant, ref_busy}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(dram_ras_n && dram_cas_n && !ref_busy, "R1 after release", {dram_ras_n, dram_cas_n}, 3);
    mon_en = 1; chk_int = 1;

    // idle phase: engine strobes held low but not requesting
    repeat (22 * IVL) @(negedge clk);
    chk(pulses >= 20, "R5 refresh count", pulses, 20);
    chk_int = 0;

    // grant latency after a refresh completes
    while (!ref_busy) @(negedge clk);
    while (ref_busy) @(negedge clk);
    do_access(5, 4'h9, w, rf);
    chk(w == 1, "R10 grant latency", w, 1);
    chk(!rf, "R10 no refresh before grant", rf, 0);

    // long access spans an expiry, then a waiting request
    do_access(60, 4'h5, w, rf);
    do_access(3, 4'hA, w, rf);
    chk(rf, "R8 pending refresh first", rf, 1);

    // sweep access lengths
    for (int len = 1; len <= 12; len++) begin
      do_access(len, AW'(len), w, rf);
      repeat (len) @(negedge clk);
    end

    repeat (6 * IVL) @(negedge clk);
    chk(pulses >= 30, "R4 rows kept cycling", pulses, 30);
    done = 1;
    report();
  end

endmodule